// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Dead Time

This block turns a bridge command and a current-direction bit into the four gate commands of an H-bridge: a high-side and a low-side switch for each of its two legs, A and B. The command asks for one of four bridge states: off, drive, fast decay or slow decay. A per-leg sequencer never lets one switch hand over straight to its complement. It first turns the conducting switch off. It then waits a dead time, counted in master-clock ticks, before it turns the other switch on. The dead time is half of a programmable blanking setting.

During decay the block applies one of three synchronous-rectification policies. With rectification disabled, no extra switch conducts while current recirculates. In active mode, rectification ends when the load current reaches zero, so the current cannot reverse. In passive mode, the current may reverse, but rectification ends if the reversed current reaches the trip level. Once rectification has been ended, it stays off until the next drive state. Three global inputs force every gate low at once: an active-high disable pin, a run bit at 0, or a fault. The sequencers behind these inputs keep running.

All inputs are plain level controls that the block samples on every clock. There is no data stream, so there is no valid/ready handshake and no back-pressure. The master-clock tick is a one-cycle enable pulse from a divider outside the block.

Top module: `fb_gate_seq`

## Requirements
- R1: While reset is asserted, all four gate outputs are low. After reset, a leg turns a switch on only after the full dead-time wait of R4, counted from the release of reset.
- R2: The drive state is `bridge_cmd` = 01. With `phase` = 0, leg A has its low side on and leg B has its high side on. With `phase` = 1, leg A has its high side on and leg B has its low side on.
- R3: The high-side and low-side outputs of one leg are never high in the same cycle, including during reset, state changes and phase changes.
- R4: When a leg must change switches, the conducting switch turns off at the next clock edge. The new switch turns on only after D+1 master-clock ticks have been seen since that turn-off. D is 2, 3, 4 or 6 for `blank_sel` codes 00, 01, 10 and 11. The actual gap is therefore between D and D+1 tick periods.
- R5: Fast decay is `bridge_cmd` = 10. While rectification is allowed, the opposite diagonal conducts: phase 0 gives A high and B low, and phase 1 gives A low and B high. When `sr_sel` is 00 or 01 (disabled), or after rectification has been ended, all gates are off.
- R6: Slow decay is `bridge_cmd` = 11. While rectification is allowed, both legs have their low side on. Otherwise, only the leg that was low in drive for the current phase keeps its low side on (A for phase 0, B for phase 1), and the other leg is off.
- R7: In active mode (`sr_sel` = 10), `zero_det` high during a decay state ends rectification in that same cycle, and `rev_trip` has no effect. In passive mode (`sr_sel` = 11), `rev_trip` high ends rectification, and `zero_det` has no effect.
- R8: Once rectification has been ended, it stays ended after the ending input falls, through later decay and off states. The next drive state clears it.
- R9: The off state (`bridge_cmd` = 00) turns every switch off at the next clock edge.
- R10: `enable_n` high, `run_en` low or `fault` high forces all four outputs low in the same cycle. The legs keep sequencing, so when the force ends, the outputs show the sequencer state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mck_tick | input | 1 | One-cycle master-clock tick enable |
| bridge_cmd | input | 2 | Bridge state: 00 off, 01 drive, 10 fast decay, 11 slow decay |
| phase | input | 1 | Current direction |
| blank_sel | input | 2 | Blanking code; the dead time is half the blank time |
| sr_sel | input | 2 | Rectification policy: 0x disabled, 10 active, 11 passive |
| zero_det | input | 1 | Zero load current detected |
| rev_trip | input | 1 | Reversed current reached the trip level |
| enable_n | input | 1 | High forces all gates off |
| run_en | input | 1 | Low (idle) forces all gates off |
| fault | input | 1 | High forces all gates off |
| gate_hi_a | output | 1 | Leg A high-side gate command |
| gate_lo_a | output | 1 | Leg A low-side gate command |
| gate_hi_b | output | 1 | Leg B high-side gate command |
| gate_lo_b | output | 1 | Leg B low-side gate command |

## Verification
The hardest situations to reach are those where a sticky end of rectification meets a dead-time wait. An example is a zero-current pulse that arrives while a leg is still counting ticks toward its rectifying switch. A later slow decay must then keep only the sink leg on. The stimulus moves from drive into decay, pulses the detector inputs in both policies, and only then moves to another decay or off state before returning to drive. It also raises each global disable in the middle of a dead-time count, to show that the count keeps going. A behavioural model in the bench tracks each leg's state and elapsed ticks, and the outputs are compared with it on every clock.

// File: rtl/fbgs_pkg.sv
package fbgs_pkg;

  // Bridge state command encoding
  typedef enum logic [1:0] {
    BR_OFF   = 2'b00,
    BR_DRIVE = 2'b01,
    BR_FAST  = 2'b10,
    BR_SLOW  = 2'b11
  } bridge_e;

  // Which switch of a leg conducts
  typedef enum logic [1:0] {
    SW_NONE = 2'b00,
    SW_HIGH = 2'b01,
    SW_LOW  = 2'b10
  } leg_e;

  localparam logic [1:0] SR_ACTIVE  = 2'b10;
  localparam logic [1:0] SR_PASSIVE = 2'b11;

  // Largest dead time (code 11), in master-clock periods
  localparam int unsigned DEAD_MAX = 6;

  // Dead time is half the blanking time selected by the code
  function automatic int unsigned dead_periods(input logic [1:0] code);
    case (code)
      2'b00:   return 2;
      2'b01:   return 3;
      2'b10:   return 4;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/fbgs_target.sv
module fbgs_target
  import fbgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bridge_cmd,
  input  logic       phase,
  input  logic [1:0] sr_sel,
  input  logic       zero_det,
  input  logic       rev_trip,
  output leg_e       want_a,
  output leg_e       want_b
);

  bridge_e cmd;
  logic    decaying;
  logic    stop_now;
  logic    stopped_q;
  logic    rect_ok;

  assign cmd      = bridge_e'(bridge_cmd);
  assign decaying = (cmd == BR_FAST) || (cmd == BR_SLOW);

  // The end condition for rectification depends on the policy
  assign stop_now = decaying &&
                    (((sr_sel == SR_ACTIVE)  && zero_det) ||
                     ((sr_sel == SR_PASSIVE) && rev_trip));
  assign rect_ok  = sr_sel[1] && !stopped_q && !stop_now;

  // Sticky until the next drive state
  always_ff @(posedge clk) begin
    if (!rst_n)               stopped_q <= 1'b0;
    else if (cmd == BR_DRIVE) stopped_q <= 1'b0;
    else if (stop_now)        stopped_q <= 1'b1;
  end

  always_comb begin
    want_a = SW_NONE;
    want_b = SW_NONE;
    case (cmd)
      BR_DRIVE: begin
        want_a = phase ? SW_HIGH : SW_LOW;
        want_b = phase ? SW_LOW  : SW_HIGH;
      end
      BR_FAST: begin
        if (rect_ok) begin
          want_a = phase ? SW_LOW  : SW_HIGH;
          want_b = phase ? SW_HIGH : SW_LOW;
        end
      end
      BR_SLOW: begin
        if (rect_ok) begin
          want_a = SW_LOW;
          want_b = SW_LOW;
        end else if (phase) begin
          want_b = SW_LOW;
        end else begin
          want_a = SW_LOW;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fbgs_leg_seq.sv
module fbgs_leg_seq
  import fbgs_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mck_tick,
  input  leg_e             want,
  input  logic [CNT_W-1:0] need_ticks,
  output leg_e             state
);

  leg_e             st_q;
  logic [CNT_W-1:0] ticks_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SW_NONE;
      ticks_q <= '0;
    end else if (st_q != SW_NONE) begin
      // Leave a conducting switch through the all-off state only
      if (want != st_q) begin
        st_q    <= SW_NONE;
        ticks_q <= '0;
      end
    end else if ((want != SW_NONE) && (ticks_q >= need_ticks)) begin
      st_q <= want;
    end else if (mck_tick && (ticks_q < need_ticks)) begin
      ticks_q <= ticks_q + 1'b1;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/fb_gate_seq.sv
module fb_gate_seq
  import fbgs_pkg::*;
#(
  parameter int unsigned ALIGN_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mck_tick,
  input  logic [1:0] bridge_cmd,
  input  logic       phase,
  input  logic [1:0] blank_sel,
  input  logic [1:0] sr_sel,
  input  logic       zero_det,
  input  logic       rev_trip,
  input  logic       enable_n,
  input  logic       run_en,
  input  logic       fault,
  output logic       gate_hi_a,
  output logic       gate_lo_a,
  output logic       gate_hi_b,
  output logic       gate_lo_b
);

  localparam int unsigned NUM_LEGS = 2;
  localparam int unsigned NEED_MAX = DEAD_MAX + ALIGN_TICKS;
  localparam int unsigned CNT_W    = $clog2(NEED_MAX + 1);

  leg_e             want [NUM_LEGS];
  leg_e             leg  [NUM_LEGS];
  logic [CNT_W-1:0] need;
  logic             blocked;

  assign need    = CNT_W'(dead_periods(blank_sel) + ALIGN_TICKS);
  assign blocked = enable_n || !run_en || fault;

  fbgs_target u_target (
    .clk        (clk),
    .rst_n      (rst_n),
    .bridge_cmd (bridge_cmd),
    .phase      (phase),
    .sr_sel     (sr_sel),
    .zero_det   (zero_det),
    .rev_trip   (rev_trip),
    .want_a     (want[0]),
    .want_b     (want[1])
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    fbgs_leg_seq #(.CNT_W(CNT_W)) u_leg (
      .clk        (clk),
      .rst_n      (rst_n),
      .mck_tick   (mck_tick),
      .want       (want[g]),
      .need_ticks (need),
      .state      (leg[g])
    );
  end

  assign gate_hi_a = !blocked && (leg[0] == SW_HIGH);
  assign gate_lo_a = !blocked && (leg[0] == SW_LOW);
  assign gate_hi_b = !blocked && (leg[1] == SW_HIGH);
  assign gate_lo_b = !blocked && (leg[1] == SW_LOW);

endmodule

// File: rtl/fbgs_chk.sv
module fbgs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bridge_cmd,
  input logic [1:0] sr_sel,
  input logic       enable_n,
  input logic       run_en,
  input logic       fault,
  input logic       gate_hi_a,
  input logic       gate_lo_a,
  input logic       gate_hi_b,
  input logic       gate_lo_b
);

  logic blocked;
  logic any_on;
  assign blocked = enable_n || !run_en || fault;
  assign any_on  = gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b;

  // R3
  leg_excl_chk: assert property (@(posedge clk)
    !(gate_hi_a && gate_lo_a) && !(gate_hi_b && gate_lo_b));

  // R10
  force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !any_on);

  // R9
  off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bridge_cmd == 2'b00) |-> !any_on);

  // R5
  fast_norect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bridge_cmd == 2'b10 && !sr_sel[1]) |-> !any_on);

  // R4
  dead_a_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi_a) && !$past(blocked)) |-> !$past(gate_lo_a));

  // R4
  dead_a_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_lo_a) && !$past(blocked)) |-> !$past(gate_hi_a));

  // R4
  dead_b_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi_b) && !$past(blocked)) |-> !$past(gate_lo_b));

  // R4
  dead_b_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_lo_b) && !$past(blocked)) |-> !$past(gate_hi_b));

endmodule

bind fb_gate_seq fbgs_chk u_fbgs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bridge_cmd (bridge_cmd),
  .sr_sel     (sr_sel),
  .enable_n   (enable_n),
  .run_en     (run_en),
  .fault      (fault),
  .gate_hi_a  (gate_hi_a),
  .gate_lo_a  (gate_lo_a),
  .gate_hi_b  (gate_hi_b),
  .gate_lo_b  (gate_lo_b)
);

// File: tb/test_fb_gate_seq.sv
`timescale 1ns/1ps
module test_fb_gate_seq;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       mck_tick = 1'b0;
  logic [1:0] bridge_cmd = 2'b00;
  logic       phase = 1'b0;
  logic [1:0] blank_sel = 2'b00;
  logic [1:0] sr_sel = 2'b00;
  logic       zero_det = 1'b0;
  logic       rev_trip = 1'b0;
  logic       enable_n = 1'b0;
  logic       run_en = 1'b1;
  logic       fault = 1'b0;
  logic       gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b;

  fb_gate_seq i_fb_gate_seq (
    .clk(clk), .rst_n(rst_n), .mck_tick(mck_tick), .bridge_cmd(bridge_cmd),
    .phase(phase), .blank_sel(blank_sel), .sr_sel(sr_sel),
    .zero_det(zero_det), .rev_trip(rev_trip), .enable_n(enable_n),
    .run_en(run_en), .fault(fault), .gate_hi_a(gate_hi_a),
    .gate_lo_a(gate_lo_a), .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string req_tag = "R1";
  bit    done = 0;

  // Master-clock tick every fourth system clock
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv     = tdiv + 1;
    mck_tick = (tdiv % 4 == 0);
  end

  // Behavioural reference: per leg 0 = off, 1 = high on, 2 = low on
  int mleg [2];
  int mticks [2];
  bit mstop;

  always @(posedge clk) begin
    int  tgt [2];
    int  need;
    bit  stop_now;
    bit  rect;
    if (!rst_n) begin
      mleg[0] = 0; mleg[1] = 0; mticks[0] = 0; mticks[1] = 0; mstop = 0;
    end else begin
      stop_now = (bridge_cmd[1]) &&
                 ((sr_sel == 2'b10 && zero_det) || (sr_sel == 2'b11 && rev_trip));
      rect = sr_sel[1] && !mstop && !stop_now;
      tgt[0] = 0; tgt[1] = 0;
      if (bridge_cmd == 2'b01) begin
        tgt[0] = phase ? 1 : 2; tgt[1] = phase ? 2 : 1;
      end else if (bridge_cmd == 2'b10 && rect) begin
        tgt[0] = phase ? 2 : 1; tgt[1] = phase ? 1 : 2;
      end else if (bridge_cmd == 2'b11) begin
        if (rect) begin tgt[0] = 2; tgt[1] = 2; end
        else if (phase) tgt[1] = 2;
        else tgt[0] = 2;
      end
      if (bridge_cmd == 2'b01) mstop = 0;
      else if (stop_now) mstop = 1;
      case (blank_sel)
        2'b00: need = 3;
        2'b01: need = 4;
        2'b10: need = 5;
        default: need = 7;
      endcase
      for (int l = 0; l < 2; l++) begin
        if (mleg[l] != 0) begin
          if (tgt[l] != mleg[l]) begin mleg[l] = 0; mticks[l] = 0; end
        end else if (tgt[l] != 0 && mticks[l] >= need) begin
          mleg[l] = tgt[l];
        end else if (mck_tick && mticks[l] < need) begin
          mticks[l] = mticks[l] + 1;
        end
      end
    end
  end

  task automatic cmp(input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req_tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit blk;
    #5;
    if (!done) begin
      blk = enable_n || !run_en || fault;
      cmp("gate_hi_a", gate_hi_a, !blk && mleg[0] == 1);
      cmp("gate_lo_a", gate_lo_a, !blk && mleg[0] == 2);
      cmp("gate_hi_b", gate_hi_b, !blk && mleg[1] == 1);
      cmp("gate_lo_b", gate_lo_b, !blk && mleg[1] == 2);
      // R3 same-leg exclusion seen at the ports
      cmp("R3 leg A exclusive", gate_hi_a && gate_lo_a, 1'b0);
      cmp("R3 leg B exclusive", gate_hi_b && gate_lo_b, 1'b0);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] cmd, input logic ph);
    @(negedge clk);
    bridge_cmd = cmd;
    phase      = ph;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL %s watchdog actual=running expected=finished", req_tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then first turn-on waits the dead time
    req_tag = "R1";
    wait_cyc(6);
    cmp("R1 reset all off", gate_hi_a | gate_lo_a | gate_hi_b | gate_lo_b, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    drive(2'b01, 1'b1);
    wait_cyc(3);
    cmp("R1 no early turn-on", gate_hi_a | gate_lo_b, 1'b0);

    // R2: drive mapping for both phases
    req_tag = "R2";
    wait_cyc(30);
    cmp("R2 phase1 A high", gate_hi_a, 1'b1);
    cmp("R2 phase1 B low", gate_lo_b, 1'b1);

    // R4: hand-over for each blanking code
    req_tag = "R4";
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); blank_sel = c[1:0];
      drive(2'b01, c[0] ? 1'b1 : 1'b0);
      wait_cyc(40);
      drive(2'b01, c[0] ? 1'b0 : 1'b1);
      wait_cyc(40);
    end
    req_tag = "R2";
    drive(2'b01, 1'b0);
    @(negedge clk); blank_sel = 2'b00;
    wait_cyc(40);
    cmp("R2 phase0 A low", gate_lo_a, 1'b1);
    cmp("R2 phase0 B high", gate_hi_b, 1'b1);

    // R5: fast decay, rectification disabled (00 and 01) then active
    req_tag = "R5";
    @(negedge clk); sr_sel = 2'b00;
    drive(2'b10, 1'b0); wait_cyc(30);
    drive(2'b01, 1'b0); wait_cyc(30);
    @(negedge clk); sr_sel = 2'b01;
    drive(2'b10, 1'b0); wait_cyc(30);
    drive(2'b01, 1'b1); wait_cyc(30);
    @(negedge clk); sr_sel = 2'b10;
    drive(2'b10, 1'b1); wait_cyc(40);
    cmp("R5 fast rect A low", gate_lo_a, 1'b1);

    // R7/R8: active mode zero detect ends rectification, rev_trip ignored
    req_tag = "R7";
    @(negedge clk); rev_trip = 1'b1;
    wait_cyc(8);
    @(negedge clk); rev_trip = 1'b0; zero_det = 1'b1;
    wait_cyc(2);
    @(negedge clk); zero_det = 1'b0;
    req_tag = "R8";
    wait_cyc(20);
    drive(2'b11, 1'b1); wait_cyc(30);
    cmp("R8 slow sink only after stop", gate_lo_a, 1'b0);
    drive(2'b00, 1'b1); wait_cyc(10);
    drive(2'b01, 1'b1); wait_cyc(30);

    // R6: slow decay with rectification (passive) and without
    req_tag = "R6";
    @(negedge clk); sr_sel = 2'b11;
    drive(2'b11, 1'b1); wait_cyc(30);
    cmp("R6 slow both low", gate_lo_a & gate_lo_b, 1'b1);
    req_tag = "R7";
    @(negedge clk); zero_det = 1'b1;
    wait_cyc(6);
    @(negedge clk); zero_det = 1'b0; rev_trip = 1'b1;
    @(negedge clk); rev_trip = 1'b0;
    wait_cyc(20);
    drive(2'b10, 1'b1); wait_cyc(30);
    drive(2'b01, 1'b0); wait_cyc(30);
    req_tag = "R6";
    @(negedge clk); sr_sel = 2'b00;
    drive(2'b11, 1'b0); wait_cyc(30);
    cmp("R6 slow sink A only", gate_lo_a & !gate_lo_b, 1'b1);

    // R9: off state
    req_tag = "R9";
    drive(2'b00, 1'b0); wait_cyc(5);
    drive(2'b01, 1'b1); wait_cyc(4);

    // R10: each global disable, raised mid dead-time and released
    req_tag = "R10";
    @(negedge clk); enable_n = 1'b1; wait_cyc(30);
    @(negedge clk); enable_n = 1'b0; wait_cyc(5);
    drive(2'b01, 1'b0);
    @(negedge clk); run_en = 1'b0; wait_cyc(30);
    @(negedge clk); run_en = 1'b1; wait_cyc(5);
    drive(2'b01, 1'b1);
    @(negedge clk); fault = 1'b1; wait_cyc(3);
    cmp("R10 fault forces off", gate_hi_a | gate_lo_a | gate_hi_b | gate_lo_b, 1'b0);
    wait_cyc(30);
    @(negedge clk); fault = 1'b0; wait_cyc(20);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule